// File: doc/BRIEF.md
# NAND Flash Bus Bridge

This block turns single write or read requests from a host port into cycles on a raw 8-bit NAND flash bus. On a write, two window-select bits choose the cycle type: a data cycle, a command cycle with CLE raised, or an address cycle with ALE raised. The block then runs a setup, strobe and hold sequence whose lengths come from three programmable counts in system clock cycles. A read always runs as a data cycle. It pulses RE#, captures the bus byte and returns it together with the completion pulse.

A control register in a small configuration space holds two bits for each chip, an enable bit and an assert bit. The chip's CE# goes low only when both bits are set. Device readiness is reported on `dev_ready_o`. With the default build, the ready/busy pin passes through a two-flop synchroniser. In a build without that pin, a fixed wait timer holds the ready indication low for a set number of cycles after each command cycle.

Top module: `nand_bus_if`

## Requirements
- R1: On an accepted write, `win_i` selects the cycle type and holds it for the whole transaction. 2'b00 (offset 0x0) is data with CLE and ALE low. 2'b01 (offset 0x8000) is command with CLE high. 2'b10 (offset 0x10000) is address with ALE high.
- R2: CLE and ALE are never high together. A write with `win_i` = 2'b11 would raise both, so it is rejected. `err_o` pulses for one cycle after the accepting edge. No strobe, CLE, ALE or `done_o` follows, and `busy_o` stays low.
- R3: An accepted write keeps WE# high for `t_setup_i` cycles, then low for `t_pulse_i` cycles, then high for `t_hold_i` cycles. `nand_dq_oe_o` stays high and `nand_dq_o` holds the write byte for the whole span. `done_o` pulses in the cycle after the hold ends. WE# and RE# are never low together.
- R4: A timing count of zero acts as one cycle.
- R5: A read ignores `win_i` and runs as a data cycle with CLE and ALE low. RE# is low for the pulse count. `rdata_o` carries `nand_dq_i` as sampled on the edge that ends the RE# pulse, and is valid while `done_o` is high.
- R6: Requests that arrive while `busy_o` is high are ignored.
- R7: The control register answers only at configuration offset 0x50. It resets to zero, which keeps every CE# high. Writes to any other offset have no effect.
- R8: CE# of chip x is low exactly when control bit 2x (enable) and bit 2x+1 (assert) are both set. The change shows in the cycle after the write.
- R9: When the ready/busy pin is used, `dev_ready_o` equals `nand_rb_i` delayed by two clock edges. It reads 0 for the first two cycles after reset.
- R10: Without the pin, `dev_ready_o` is high from reset. It falls in the cycle after `done_o` of a command cycle and stays low for `WAIT_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken when not busy |
| we_i | input | 1 | 1 = write, 0 = read |
| win_i | input | 2 | Window-select bits (offset bits 16:15) |
| wdata_i | input | DW | Write byte |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle rejection pulse |
| rdata_o | output | DW | Read byte, valid with done_o |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | RAW | Configuration offset |
| cfg_wdata_i | input | 2*NCHIP | Configuration write data |
| t_setup_i | input | TW | Setup cycles |
| t_pulse_i | input | TW | Strobe low cycles |
| t_hold_i | input | TW | Hold cycles |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_ce_no | output | NCHIP | Chip enables, active low |
| nand_dq_o | output | DW | Bus data out |
| nand_dq_oe_o | output | 1 | Bus output enable |
| nand_dq_i | input | DW | Bus data in |
| nand_rb_i | input | 1 | Device ready (1) / busy (0) |
| dev_ready_o | output | 1 | Reported device readiness |

## Verification
Every output is registered, so each result is due a fixed number of edges after its cause.

- CLE, ALE, bus enable and the setup phase appear one edge after the accepting edge.
- WE# or RE# falls after `max(t_setup_i,1)` further edges.
- `done_o` follows after `max(t_pulse_i,1)+max(t_hold_i,1)` more edges.
- `err_o` and a new CE# value appear one edge after their request.
- `dev_ready_o` lags the pin by two edges, or drops one edge after a command's `done_o`.

A behavioural model steps these counts forward on each rising edge. The bench compares every output against the model at each falling edge, so each result is checked exactly in the cycle it is due.

// File: rtl/nand_bus_pkg.sv
package nand_bus_pkg;
  typedef enum logic [1:0] {
    CYC_DATA = 2'b00,
    CYC_CMD  = 2'b01,
    CYC_ADDR = 2'b10,
    CYC_BAD  = 2'b11
  } cyc_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD
  } phase_e;
endpackage

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nand_bus_pkg::*;
#(
  parameter int DW = 8,
  parameter int TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wr_i,
  input  cyc_kind_e     kind_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [TW-1:0] t_setup_i,
  input  logic [TW-1:0] t_pulse_i,
  input  logic [TW-1:0] t_hold_i,
  input  logic [DW-1:0] dq_i,
  output logic          busy_o,
  output logic          cle_o,
  output logic          ale_o,
  output logic          we_no,
  output logic          re_no,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic          done_o,
  output logic          done_cmd_o,
  output logic [DW-1:0] rdata_o
);
  phase_e        ph_q;
  logic [TW-1:0] cnt_q, tp_q, th_q;
  logic          wr_q, done_q, done_cmd_q;
  cyc_kind_e     kind_q;
  logic [DW-1:0] data_q, rdata_q;

  // zero count behaves as one cycle
  function automatic logic [TW-1:0] len_m1(input logic [TW-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= PH_IDLE;
      cnt_q      <= '0;
      tp_q       <= '0;
      th_q       <= '0;
      wr_q       <= 1'b0;
      kind_q     <= CYC_DATA;
      data_q     <= '0;
      rdata_q    <= '0;
      done_q     <= 1'b0;
      done_cmd_q <= 1'b0;
    end else begin
      done_q     <= 1'b0;
      done_cmd_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q   <= PH_SETUP;
          cnt_q  <= len_m1(t_setup_i);
          tp_q   <= len_m1(t_pulse_i);
          th_q   <= len_m1(t_hold_i);
          wr_q   <= wr_i;
          kind_q <= kind_i;
          data_q <= wdata_i;
        end
        PH_SETUP: if (cnt_q == '0) begin
          ph_q  <= PH_PULSE;
          cnt_q <= tp_q;
        end else cnt_q <= cnt_q - 1'b1;
        PH_PULSE: if (cnt_q == '0) begin
          ph_q  <= PH_HOLD;
          cnt_q <= th_q;
          if (!wr_q) rdata_q <= dq_i;
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (cnt_q == '0) begin
          ph_q       <= PH_IDLE;
          done_q     <= 1'b1;
          done_cmd_q <= wr_q && (kind_q == CYC_CMD);
        end else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  logic active;
  assign active     = (ph_q != PH_IDLE);
  assign busy_o     = active;
  assign cle_o      = active && (kind_q == CYC_CMD);
  assign ale_o      = active && (kind_q == CYC_ADDR);
  assign we_no      = !(ph_q == PH_PULSE && wr_q);
  assign re_no      = !(ph_q == PH_PULSE && !wr_q);
  assign dq_oe_o    = active && wr_q;
  assign dq_o       = data_q;
  assign done_o     = done_q;
  assign done_cmd_o = done_cmd_q;
  assign rdata_o    = rdata_q;

  assert_strobe_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no));

  assert_ctl_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(cle_o) && $stable(ale_o) && $stable(dq_oe_o)));

  assert_done_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && we_no && re_no));
endmodule

// File: rtl/nand_ce_reg.sv
module nand_ce_reg #(
  parameter int              NCHIP    = 2,
  parameter int              RAW      = 8,
  parameter logic [RAW-1:0]  CTRL_OFS = 8'h50
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [RAW-1:0]       cfg_addr_i,
  input  logic [2*NCHIP-1:0]   cfg_wdata_i,
  output logic [NCHIP-1:0]     ce_no
);
  localparam int CTRLW = 2 * NCHIP;
  logic [CTRLW-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (cfg_we_i && cfg_addr_i == CTRL_OFS) ctrl_q <= cfg_wdata_i;
  end

  for (genvar c = 0; c < NCHIP; c++) begin : g_ce
    // even bit: enable, odd bit: assert
    assign ce_no[c] = !(ctrl_q[2*c] && ctrl_q[2*c+1]);
  end
endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rb_i,
  output logic ready_o
);
  logic s1_q, s2_q;
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      age_q <= '0;
    end else begin
      s1_q <= rb_i;
      s2_q <= s1_q;
      if (age_q != 2'd2) age_q <= age_q + 1'b1;
    end
  end

  assign ready_o = s2_q;

  assert_sync_lag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (ready_o == $past(rb_i, 2)));
endmodule

// File: rtl/nand_wait_timer.sv
module nand_wait_timer #(
  parameter int WAIT_CYC = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_done_i,
  output logic ready_o
);
  localparam int CW = $clog2(WAIT_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cmd_done_i)      cnt_q <= CW'(WAIT_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = (cnt_q == '0);

  assert_wait_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_i |=> !ready_o);
endmodule

// File: rtl/nand_bus_if.sv
module nand_bus_if
  import nand_bus_pkg::*;
#(
  parameter int             DW       = 8,
  parameter int             TW       = 4,
  parameter int             NCHIP    = 2,
  parameter int             RAW      = 8,
  parameter logic [RAW-1:0] CTRL_OFS = 8'h50,
  parameter bit             USE_RB   = 1'b1,
  parameter int             WAIT_CYC = 5000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [1:0]           win_i,
  input  logic [DW-1:0]        wdata_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 err_o,
  output logic [DW-1:0]        rdata_o,
  input  logic                 cfg_we_i,
  input  logic [RAW-1:0]       cfg_addr_i,
  input  logic [2*NCHIP-1:0]   cfg_wdata_i,
  input  logic [TW-1:0]        t_setup_i,
  input  logic [TW-1:0]        t_pulse_i,
  input  logic [TW-1:0]        t_hold_i,
  output logic                 nand_cle_o,
  output logic                 nand_ale_o,
  output logic                 nand_we_no,
  output logic                 nand_re_no,
  output logic [NCHIP-1:0]     nand_ce_no,
  output logic [DW-1:0]        nand_dq_o,
  output logic                 nand_dq_oe_o,
  input  logic [DW-1:0]        nand_dq_i,
  input  logic                 nand_rb_i,
  output logic                 dev_ready_o
);
  logic      accept, bad_win, start, err_q, done_cmd;
  cyc_kind_e kind;

  assign accept  = req_i && !busy_o;
  assign bad_win = we_i && (cyc_kind_e'(win_i) == CYC_BAD);
  assign start   = accept && !bad_win;
  // reads always use the data window
  assign kind    = we_i ? cyc_kind_e'(win_i) : CYC_DATA;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= accept && bad_win;
  end
  assign err_o = err_q;

  nand_strobe_seq #(.DW(DW), .TW(TW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .wr_i      (we_i),
    .kind_i    (kind),
    .wdata_i   (wdata_i),
    .t_setup_i (t_setup_i),
    .t_pulse_i (t_pulse_i),
    .t_hold_i  (t_hold_i),
    .dq_i      (nand_dq_i),
    .busy_o    (busy_o),
    .cle_o     (nand_cle_o),
    .ale_o     (nand_ale_o),
    .we_no     (nand_we_no),
    .re_no     (nand_re_no),
    .dq_o      (nand_dq_o),
    .dq_oe_o   (nand_dq_oe_o),
    .done_o    (done_o),
    .done_cmd_o(done_cmd),
    .rdata_o   (rdata_o)
  );

  nand_ce_reg #(.NCHIP(NCHIP), .RAW(RAW), .CTRL_OFS(CTRL_OFS)) u_ce (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i),
    .ce_no      (nand_ce_no)
  );

  if (USE_RB) begin : g_rb
    nand_rb_sync u_rb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rb_i   (nand_rb_i),
      .ready_o(dev_ready_o)
    );
  end else begin : g_timer
    nand_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cmd_done_i(done_cmd),
      .ready_o   (dev_ready_o)
    );
  end

  assert_cle_ale_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));

  assert_bad_reject_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && we_i && win_i == 2'b11) |=> (err_o && !busy_o));

  assert_err_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (nand_we_no && nand_re_no && !nand_cle_o && !nand_ale_o && !done_o));

  assert_cfg_other_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i != CTRL_OFS) |=> $stable(nand_ce_no));

  assert_cmd_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_cmd |-> done_o);
endmodule

// File: tb/tb_nand_bus_if.sv
module tb_nand_bus_if;
  localparam int CLK_PERIOD = 10;
  localparam int NCHIP      = 2;
  localparam int WAITC      = 12;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0, we_i = 1'b0;
  logic [1:0] win_i = 2'b00;
  logic [7:0] wdata_i = '0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_addr_i = '0;
  logic [3:0] cfg_wdata_i = '0;
  logic [3:0] t_setup_i = 4'd2, t_pulse_i = 4'd3, t_hold_i = 4'd1;
  logic [7:0] nand_dq_i = '0;
  logic       nand_rb_i = 1'b0;

  logic       busy_o, done_o, err_o, cle, ale, we_n, re_n, dq_oe, dev_ready;
  logic [7:0] rdata_o, dq_o;
  logic [NCHIP-1:0] ce_n;
  logic       t_busy, t_done, t_err, t_cle, t_ale, t_we_n, t_re_n, t_oe, t_ready;
  logic [7:0] t_rdata, t_dq;
  logic [NCHIP-1:0] t_ce_n;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  nand_bus_if dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .win_i(win_i),
    .wdata_i(wdata_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .rdata_o(rdata_o), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .t_setup_i(t_setup_i), .t_pulse_i(t_pulse_i),
    .t_hold_i(t_hold_i), .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_no(we_n),
    .nand_re_no(re_n), .nand_ce_no(ce_n), .nand_dq_o(dq_o), .nand_dq_oe_o(dq_oe),
    .nand_dq_i(nand_dq_i), .nand_rb_i(nand_rb_i), .dev_ready_o(dev_ready)
  );

  nand_bus_if #(.USE_RB(1'b0), .WAIT_CYC(WAITC)) dut_t (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .win_i(win_i),
    .wdata_i(wdata_i), .busy_o(t_busy), .done_o(t_done), .err_o(t_err),
    .rdata_o(t_rdata), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .t_setup_i(t_setup_i), .t_pulse_i(t_pulse_i),
    .t_hold_i(t_hold_i), .nand_cle_o(t_cle), .nand_ale_o(t_ale), .nand_we_no(t_we_n),
    .nand_re_no(t_re_n), .nand_ce_no(t_ce_n), .nand_dq_o(t_dq), .nand_dq_oe_o(t_oe),
    .nand_dq_i(nand_dq_i), .nand_rb_i(nand_rb_i), .dev_ready_o(t_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff(input logic [3:0] x);
    return (x == 0) ? 1 : int'(x);
  endfunction

  // behavioural reference, advanced on each rising edge
  bit m_busy, m_wr, m_done, m_err, m_done_cmd, m_rb1, m_rb2;
  int m_t, m_s, m_p, m_h, m_kind, m_tmr, n_done, wl, last_wl;
  logic [7:0] m_wd, m_rd;
  logic [3:0] m_ctrl;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_done = 0; m_err = 0; m_done_cmd = 0; m_rb1 = 0; m_rb2 = 0;
      m_tmr = 0; m_ctrl = '0; m_wr = 0; m_kind = 0; m_rd = '0; m_wd = '0;
    end else begin
      bit prev_cmd;
      prev_cmd = m_done_cmd;
      m_done = 0; m_err = 0; m_done_cmd = 0;
      m_rb2 = m_rb1; m_rb1 = nand_rb_i;
      if (prev_cmd) m_tmr = WAITC;
      else if (m_tmr > 0) m_tmr--;
      if (m_busy) begin
        m_t++;
        if (m_t == m_s + m_p && !m_wr) m_rd = nand_dq_i;
        if (m_t == m_s + m_p + m_h) begin
          m_busy = 0; m_done = 1; m_done_cmd = m_wr && m_kind == 1;
        end
      end else if (req_i) begin
        if (we_i && win_i == 2'b11) m_err = 1;
        else begin
          m_busy = 1; m_t = 0;
          m_s = eff(t_setup_i); m_p = eff(t_pulse_i); m_h = eff(t_hold_i);
          m_wr = we_i; m_kind = we_i ? int'(win_i) : 0; m_wd = wdata_i;
        end
      end
      if (cfg_we_i && cfg_addr_i == 8'h50) m_ctrl = cfg_wdata_i;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      bit pulse;
      pulse = m_busy && m_t >= m_s && m_t < m_s + m_p;
      chk("R1 cle", cle, m_busy && m_kind == 1);
      chk("R1 ale", ale, m_busy && m_kind == 2);
      chk("R3 we_n", we_n, !(pulse && m_wr));
      chk("R5 re_n", re_n, !(pulse && !m_wr));
      chk("R3 dq_oe", dq_oe, m_busy && m_wr);
      if (m_busy && m_wr) chk("R3 dq", dq_o, m_wd);
      chk("R6 busy", busy_o, m_busy);
      chk("R3 done", done_o, m_done);
      chk("R2 err", err_o, m_err);
      if (m_done && !m_wr) chk("R5 rdata", rdata_o, m_rd);
      for (int c = 0; c < NCHIP; c++)
        chk("R8 ce_n", ce_n[c], !(m_ctrl[2*c] && m_ctrl[2*c+1]));
      chk("R9 dev_ready", dev_ready, m_rb2);
      chk("R10 timer ready", t_ready, m_tmr == 0);
      if (done_o) n_done++;
      if (!we_n) wl++;
      else if (wl > 0) begin last_wl = wl; wl = 0; end
    end
  end

  task automatic xfer(input bit wr, input logic [1:0] w, input logic [7:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = wr; win_i = w; wdata_i = d;
    @(negedge clk_i);
    req_i = 0;
    while (busy_o) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic cfg(input logic [7:0] a, input logic [3:0] d);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 0;
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int nd;
    repeat (3) @(negedge clk_i);
    chk("R7 reset ce_n", ce_n, 2'b11);
    chk("R7 reset busy", busy_o, 0);
    rst_ni = 1;
    nand_rb_i = 1;
    cfg(8'h50, 4'b0011);
    chk("R8 chip0 on", ce_n, 2'b10);
    xfer(1, 2'b01, 8'h70);            // R1 command
    xfer(1, 2'b10, 8'h12);            // R1 address
    nand_rb_i = 0;
    xfer(1, 2'b00, 8'hA5);            // R1/R3 data
    nand_rb_i = 1;
    xfer(1, 2'b11, 8'hEE);            // R2 rejected
    nand_dq_i = 8'h3C;
    xfer(0, 2'b01, 8'h00);            // R5 read ignores window
    t_setup_i = 0; t_pulse_i = 0; t_hold_i = 0;
    xfer(1, 2'b00, 8'h5A);
    chk("R4 we_n low width", last_wl, 1);
    t_setup_i = 3; t_pulse_i = 2; t_hold_i = 2;
    nand_dq_i = 8'hC3;
    xfer(0, 2'b10, 8'h00);
    // R6: keep requesting while busy
    nd = n_done;
    @(negedge clk_i);
    req_i = 1; we_i = 1; win_i = 2'b00; wdata_i = 8'h11;
    @(negedge clk_i);
    wdata_i = 8'h22; win_i = 2'b01;
    repeat (4) @(negedge clk_i);
    req_i = 0;
    while (busy_o) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
    chk("R6 one transaction", n_done - nd, 1);
    cfg(8'h30, 4'b1111);
    chk("R7 other offset ignored", ce_n, 2'b10);
    cfg(8'h50, 4'b1110);
    chk("R8 chip1 only", ce_n, 2'b01);
    cfg(8'h50, 4'b0111);
    chk("R8 chip0 assert only", ce_n, 2'b10);
    xfer(1, 2'b01, 8'hFF);            // R10 wait after command
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      nand_rb_i = i[0];
    end
    repeat (WAITC + 4) @(negedge clk_i);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule